// File: doc/BRIEF.md
# Accumulator Arithmetic Unit

This block is the arithmetic execution stage of a small 8-bit processor core. It holds seven byte registers, a 16-bit stack pointer and a five-bit flag register. Each cycle it may take one decoded operation and carry it out. The supported operations are:

- accumulator add and subtract, each with or without the incoming carry or borrow;
- in-place increment or decrement of a byte register or of the memory byte;
- increment or decrement of a 16-bit register pair;
- a 16-bit add into the HL pair.

The decoder in front of the block supplies the operation code, a byte-operand selector, a pair selector, an immediate-select bit and the immediate byte. The memory byte is always the one that HL points at. The block shows HL on `mem_addr` and reads the external byte from `mem_rdata` in the same cycle. For an in-place memory increment or decrement, the block returns the new byte on `mem_wdata` with a one-cycle `mem_we` strobe.

All state updates on the rising edge at which `op_valid` is sampled high. The register contents, flags and memory write strobe are registered outputs.

Top module: `acc_arith_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all byte registers, SP and all flags to zero and deasserts `mem_we`.
- R2: `op`=1 (add) writes A+operand to A. The operand is `imm` when `use_imm`=1. Otherwise `src_sel` picks it: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte, 7=A. The flags are `flags_o`[4]=S (result bit 7), [3]=Z (result zero), [2]=AC (carry out of bit 3), [1]=P (even parity of the result) and [0]=CY (carry out of bit 7), and all five are updated.
- R3: `op`=2 (add with carry) behaves like R2 but also adds the current CY as a third term.
- R4: `op`=3 (subtract) and `op`=4 (subtract with borrow) compute A + ~operand + (1 - borrow-in) into A. The borrow-in is 0 for `op`=3 and the current CY for `op`=4. AC is the carry out of bit 3 of that sum, and CY is set on a borrow. For example, 37h minus 40h gives F7h with CY=1.
- R5: When `src_sel`=6, add and subtract read the byte on `mem_rdata`, addressed by `mem_addr`=HL, and never assert `mem_we`.
- R6: `op`=5 (increment) and `op`=6 (decrement) with `src_sel` 0 to 5 or 7 change that register by one, with wrap-around. They update S, Z, AC and P and leave CY unchanged. AC is set on an increment from xFh and on a decrement from a value whose low nibble is not zero.
- R7: Increment or decrement with `src_sel`=6 leaves the registers unchanged. In the next cycle it presents `mem_rdata`±1 on `mem_wdata` with `mem_we`=1 for one cycle. Its flags follow R6.
- R8: `op`=7 (pair increment) and `op`=8 (pair decrement) change the pair picked by `pair_sel` (0=BC, 1=DE, 2=HL, 3=SP) by one modulo 65536 and leave every flag unchanged.
- R9: `op`=9 writes HL + pair (picked by `pair_sel` as in R8) to HL. It sets CY to the carry out of bit 15 and holds S, Z, AC and P.
- R10: With `op_valid`=0, or with `op`=0, no register, flag or memory write strobe changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Decoded operation code |
| src_sel | input | 3 | Byte operand / target selector |
| pair_sel | input | 2 | Register pair selector |
| use_imm | input | 1 | Take the add/subtract operand from `imm` |
| imm | input | 8 | Immediate byte |
| mem_rdata | input | 8 | Memory byte at `mem_addr` |
| mem_addr | output | 16 | Memory pointer (HL) |
| mem_wdata | output | 8 | Write-back byte for memory increment/decrement |
| mem_we | output | 1 | Write strobe, one cycle |
| acc_o | output | 8 | Accumulator A |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| reg_d | output | 8 | Register D |
| reg_e | output | 8 | Register E |
| reg_h | output | 8 | Register H |
| reg_l | output | 8 | Register L |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 5 | {S, Z, AC, P, CY} |

## Verification
In several cases an operand's read and its write fall on the same edge. Add or subtract with `src_sel`=7 reads the accumulator while replacing it. A 16-bit add with the HL pair selected reads HL as both terms while overwriting it. A memory increment or decrement reads the byte at HL and writes the new value back to the same address. The bench provokes these cases with a directed subtract of A, a doubling add of HL, and a pseudo-random stream that often picks the accumulator, HL and the memory selector. A bench-side arithmetic model judges each case from the pre-edge values, so any read of an already-updated value shows up as a miscompare.

// File: rtl/acu_pkg.sv
package acu_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SUB  = 4'd3,
    OP_SBB  = 4'd4,
    OP_INR  = 4'd5,
    OP_DCR  = 4'd6,
    OP_INX  = 4'd7,
    OP_DCX  = 4'd8,
    OP_DAD  = 4'd9
  } acu_op_e;

  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam logic [2:0] SEL_ACC = 3'd7;

  localparam int FL_S  = 4;
  localparam int FL_Z  = 3;
  localparam int FL_AC = 2;
  localparam int FL_P  = 1;
  localparam int FL_CY = 0;
  localparam int NFLAG = 5;

  typedef enum logic [1:0] {
    WM_INC = 2'd0,
    WM_DEC = 2'd1,
    WM_ADD = 2'd2
  } wide_mode_e;
endpackage

// File: rtl/acu_alu8.sv
module acu_alu8 #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          hc,
  output logic          zf,
  output logic          sf,
  output logic          pf
);
  localparam int NW = 4;

  logic [DW-1:0] bx;
  logic          cx;
  logic [DW:0]   full;
  logic [NW:0]   nib;

  always_comb begin
    bx   = sub ? ~b : b;
    cx   = sub ^ cin;
    nib  = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cx};
    full = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cx};
    res  = full[DW-1:0];
    cy   = full[DW] ^ sub;
    hc   = nib[NW];
    zf   = (full[DW-1:0] == '0);
    sf   = full[DW-1];
    pf   = ~^full[DW-1:0];
  end
endmodule

// File: rtl/acu_wide16.sv
module acu_wide16 #(
  parameter int WW = 16
) (
  input  logic [WW-1:0] pv,
  input  logic [WW-1:0] hl,
  input  logic [1:0]    mode,
  output logic [WW-1:0] res,
  output logic          co
);
  import acu_pkg::*;

  always_comb begin
    co  = 1'b0;
    res = pv;
    case (wide_mode_e'(mode))
      WM_INC:  res = pv + WW'(1);
      WM_DEC:  res = pv - WW'(1);
      WM_ADD:  {co, res} = {1'b0, hl} + {1'b0, pv};
      default: res = pv;
    endcase
  end
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op,
  input  logic [2:0]    src_sel,
  input  logic [1:0]    pair_sel,
  input  logic          use_imm,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] reg_b,
  output logic [DW-1:0] reg_c,
  output logic [DW-1:0] reg_d,
  output logic [DW-1:0] reg_e,
  output logic [DW-1:0] reg_h,
  output logic [DW-1:0] reg_l,
  output logic [AW-1:0] sp_o,
  output logic [4:0]    flags_o
);
  import acu_pkg::*;

  localparam int NREG = 8;

  logic [DW-1:0]    rf [NREG];
  logic [AW-1:0]    sp_q;
  logic [NFLAG-1:0] fl_q;

  acu_op_e       opc;
  logic          is_arith, is_step, is_pair;
  logic [DW-1:0] opnd, tgt;
  logic [AW-1:0] hl, pair_v;

  logic [DW-1:0] alu_a, alu_b, alu_res;
  logic          alu_cin, alu_sub, alu_cy, alu_hc, alu_z, alu_s, alu_p;
  logic [1:0]    w_mode;
  logic [AW-1:0] w_res;
  logic          w_co;

  always_comb begin
    opc      = acu_op_e'(op);
    is_arith = (opc == OP_ADD) || (opc == OP_ADC) || (opc == OP_SUB) || (opc == OP_SBB);
    is_step  = (opc == OP_INR) || (opc == OP_DCR);
    is_pair  = (opc == OP_INX) || (opc == OP_DCX) || (opc == OP_DAD);
    hl       = {rf[4], rf[5]};
    tgt      = (src_sel == SEL_MEM) ? mem_rdata : rf[src_sel];
    opnd     = use_imm ? imm : tgt;
    case (pair_sel)
      2'd0:    pair_v = {rf[0], rf[1]};
      2'd1:    pair_v = {rf[2], rf[3]};
      2'd2:    pair_v = hl;
      default: pair_v = sp_q;
    endcase
    alu_a   = is_step ? tgt : rf[SEL_ACC];
    alu_b   = is_step ? '0 : opnd;
    alu_cin = is_step ? 1'b1 : (((opc == OP_ADC) || (opc == OP_SBB)) && fl_q[FL_CY]);
    alu_sub = (opc == OP_SUB) || (opc == OP_SBB) || (opc == OP_DCR);
    case (opc)
      OP_INX:  w_mode = WM_INC;
      OP_DCX:  w_mode = WM_DEC;
      default: w_mode = WM_ADD;
    endcase
  end

  acu_alu8 #(.DW(DW)) u_alu (
    .a(alu_a), .b(alu_b), .cin(alu_cin), .sub(alu_sub),
    .res(alu_res), .cy(alu_cy), .hc(alu_hc), .zf(alu_z), .sf(alu_s), .pf(alu_p)
  );

  acu_wide16 #(.WW(AW)) u_wide (
    .pv(pair_v), .hl(hl), .mode(w_mode), .res(w_res), .co(w_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      sp_q      <= '0;
      fl_q      <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (op_valid) begin
        if (is_arith) begin
          rf[SEL_ACC] <= alu_res;
          fl_q        <= {alu_s, alu_z, alu_hc, alu_p, alu_cy};
        end else if (is_step) begin
          fl_q[NFLAG-1:1] <= {alu_s, alu_z, alu_hc, alu_p};
          if (src_sel == SEL_MEM) begin
            mem_we    <= 1'b1;
            mem_wdata <= alu_res;
          end else begin
            rf[src_sel] <= alu_res;
          end
        end else if (is_pair) begin
          case (pair_sel)
            2'd0:    {rf[0], rf[1]} <= w_res;
            2'd1:    {rf[2], rf[3]} <= w_res;
            2'd2:    {rf[4], rf[5]} <= w_res;
            default: sp_q <= w_res;
          endcase
          if (opc == OP_DAD) fl_q[FL_CY] <= w_co;
        end
      end
    end
  end

  assign mem_addr = hl;
  assign acc_o    = rf[SEL_ACC];
  assign reg_b    = rf[0];
  assign reg_c    = rf[1];
  assign reg_d    = rf[2];
  assign reg_e    = rf[3];
  assign reg_h    = rf[4];
  assign reg_l    = rf[5];
  assign sp_o     = sp_q;
  assign flags_o  = fl_q;

  // R2
  z_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_arith) |=> (flags_o[FL_Z] == (acc_o == '0)));

  // R5
  no_mem_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_arith) |=> !mem_we);

  // R6
  step_cy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_step) |=> $stable(flags_o[FL_CY]));

  // R7
  mem_step_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_step && src_sel == SEL_MEM) |=> (mem_we && $stable(acc_o) && $stable(mem_addr)));

  // R8
  pair_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (opc == OP_INX || opc == OP_DCX)) |=> $stable(flags_o));

  // R9
  wide_add_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opc == OP_DAD) |=> $stable(flags_o[NFLAG-1:1]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid) |=> ($stable(acc_o) && $stable(flags_o) && $stable(mem_addr) && !mem_we));
endmodule

// File: tb/sim_acc_arith_unit.sv
`timescale 1ns/1ps
module sim_acc_arith_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [2:0]  src_sel = 3'd0;
  logic [1:0]  pair_sel = 2'd0;
  logic        use_imm = 1'b0;
  logic [7:0]  imm = 8'd0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  acc_o, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l;
  logic [15:0] sp_o;
  logic [4:0]  flags_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [7:0]  mr [8];
  logic [15:0] msp;
  logic [4:0]  mf;
  logic        x_we;
  logic [7:0]  x_wd;
  logic [31:0] lf = 32'h1234_5678;

  always #2 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;

  acc_arith_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .src_sel(src_sel),
    .pair_sel(pair_sel), .use_imm(use_imm), .imm(imm), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .acc_o(acc_o),
    .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e), .reg_h(reg_h),
    .reg_l(reg_l), .sp_o(sp_o), .flags_o(flags_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 180000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] mem_of(input logic [7:0] h, input logic [7:0] l);
    return h ^ l ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [95:0] g, e;
    g = {10'd0, acc_o, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l, sp_o, flags_o,
         mem_we, (mem_we ? mem_wdata : 8'd0)};
    e = {10'd0, mr[7], mr[0], mr[1], mr[2], mr[3], mr[4], mr[5], msp, mf,
         x_we, (x_we ? x_wd : 8'd0)};
    check(g == e, tag, g, e);
  endtask

  task automatic model(input int o, input int sel, input int pr, input bit ui, input int im);
    int a, b, c, r, v, p, hlv;
    bit cy, ac;
    logic [7:0] rb;
    x_we = 1'b0;
    x_wd = 8'd0;
    hlv  = {mr[4], mr[5]};
    v    = (sel == 6) ? int'(mem_of(mr[4], mr[5])) : int'(mr[sel]);
    case (pr)
      0: p = {mr[0], mr[1]};
      1: p = {mr[2], mr[3]};
      2: p = hlv;
      default: p = msp;
    endcase
    if (o >= 1 && o <= 4) begin
      a = mr[7];
      b = ui ? im : v;
      c = (o == 2 || o == 4) ? int'(mf[0]) : 0;
      if (o <= 2) begin
        r  = a + b + c;
        cy = (r > 255);
        ac = ((a % 16) + (b % 16) + c) > 15;
      end else begin
        r  = a - b - c;
        cy = (r < 0);
        ac = ((a % 16) + (15 - (b % 16)) + (1 - c)) > 15;
      end
      rb = 8'(r);
      mr[7] = rb;
      mf = {rb[7], rb == 8'd0, ac, ~^rb, cy};
    end else if (o == 5 || o == 6) begin
      if (o == 5) begin
        rb = 8'(v + 1);
        ac = (v % 16) == 15;
      end else begin
        rb = 8'(v - 1);
        ac = (v % 16) != 0;
      end
      mf = {rb[7], rb == 8'd0, ac, ~^rb, mf[0]};
      if (sel == 6) begin
        x_we = 1'b1;
        x_wd = rb;
      end else begin
        mr[sel] = rb;
      end
    end else if (o >= 7 && o <= 9) begin
      if (o == 7) r = (p + 1) % 65536;
      else if (o == 8) r = (p + 65535) % 65536;
      else begin
        r = p + hlv;
        mf[0] = (r > 65535);
        r = r % 65536;
      end
      case (pr)
        0: {mr[0], mr[1]} = 16'(r);
        1: {mr[2], mr[3]} = 16'(r);
        2: {mr[4], mr[5]} = 16'(r);
        default: msp = 16'(r);
      endcase
    end
  endtask

  task automatic do_op(input bit vld, input int o, input int sel, input int pr,
                       input bit ui, input int im, input string tag);
    op_valid = vld;
    op       = 4'(o);
    src_sel  = 3'(sel);
    pair_sel = 2'(pr);
    use_imm  = ui;
    imm      = 8'(im);
    if (vld) model(o, sel, pr, ui, im);
    else x_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mr[i] = 8'd0;
    msp = 16'd0;
    mf  = 5'd0;
    x_we = 1'b0;
    x_wd = 8'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare_all("R1 reset state");

    // R6 walk B up to 40h
    for (int i = 0; i < 64; i++) do_op(1, 5, 0, 0, 0, 0, "R6 inr B");
    do_op(1, 3, 7, 0, 0, 0, "R4 sub A from A");
    do_op(1, 1, 0, 0, 1, 8'h37, "R2 add imm");
    do_op(1, 3, 0, 0, 0, 0, "R4 sub B");
    check(acc_o == 8'hF7 && flags_o[0], "R4 37h-40h gives F7h borrow",
          {80'd0, acc_o, 7'd0, flags_o[0]}, {80'd0, 8'hF7, 8'h01});

    // R10 idle and null operation
    do_op(0, 1, 0, 0, 1, 8'hFF, "R10 op_valid low");
    do_op(1, 0, 0, 0, 1, 8'hFF, "R10 null op");

    // R8 pair wrap on SP
    do_op(1, 8, 0, 3, 0, 0, "R8 dcx SP wraps to FFFF");
    do_op(1, 7, 0, 3, 0, 0, "R8 inx SP wraps to 0000");
    do_op(1, 8, 0, 0, 0, 0, "R8 dcx BC");

    // R9 HL doubling and carry
    do_op(1, 7, 0, 2, 0, 0, "R8 inx HL");
    for (int i = 0; i < 17; i++) do_op(1, 9, 0, 2, 0, 0, "R9 dad HL+HL");
    do_op(1, 9, 0, 0, 0, 0, "R9 dad BC");
    do_op(1, 9, 0, 3, 0, 0, "R9 dad SP");

    // R5 R7 memory operand and in-place step
    do_op(1, 1, 6, 0, 0, 0, "R5 add memory");
    do_op(1, 4, 6, 0, 0, 0, "R5 sbb memory");
    do_op(1, 5, 6, 0, 0, 0, "R7 inr memory");
    do_op(1, 6, 6, 0, 0, 0, "R7 dcr memory");

    // R2 R3 R4 sweep over every accumulator value, both carry-in states
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 8; bi++) begin
        for (int k = 1; k <= 4; k++) begin
          do_op(1, 3, 7, 0, 0, 0, "R4 clear A");
          if (bi[0]) do_op(1, 3, 0, 0, 1, (256 - a) % 256, "R4 sui set A, borrow");
          else       do_op(1, 1, 0, 0, 1, a, "R2 adi set A");
          case (k)
            1: do_op(1, k, 0, 0, 1, (bi * 37 + 5) % 256, "R2 add sweep");
            2: do_op(1, k, 0, 0, 1, (bi * 37 + 5) % 256, "R3 adc sweep");
            default: do_op(1, k, 0, 0, 1, (bi * 37 + 5) % 256, "R4 sub/sbb sweep");
          endcase
        end
      end
    end

    // pseudo-random mixed stream
    for (int n = 0; n < 9000; n++) begin
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
      case (1 + int'(lf[31:20]) % 9)
        1: do_op(1, 1, int'(lf[8:6]), 0, lf[9], int'(lf[17:10]), "R2 random add");
        2: do_op(1, 2, int'(lf[8:6]), 0, lf[9], int'(lf[17:10]), "R3 random adc");
        3: do_op(1, 3, int'(lf[8:6]), 0, lf[9], int'(lf[17:10]), "R4 random sub");
        4: do_op(1, 4, int'(lf[8:6]), 0, lf[9], int'(lf[17:10]), "R4 random sbb");
        5: do_op(1, 5, int'(lf[8:6]), 0, 0, 0, "R6 R7 random inr");
        6: do_op(1, 6, int'(lf[8:6]), 0, 0, 0, "R6 R7 random dcr");
        7: do_op(1, 7, 0, int'(lf[5:4]), 0, 0, "R8 random inx");
        8: do_op(1, 8, 0, int'(lf[5:4]), 0, 0, "R8 random dcx");
        default: do_op(1, 9, 0, int'(lf[5:4]), 0, 0, "R9 random dad");
      endcase
    end

    // R1 reset again from a busy state
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) mr[i] = 8'd0;
    msp = 16'd0;
    mf  = 5'd0;
    x_we = 1'b0;
    compare_all("R1 reset after traffic");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule